// File: doc/BRIEF.md
# Cartridge Bank-Switching Address Mapper

This block sits on the cartridge side of an 8-bit CPU bus. It watches CPU writes in the upper half of the address space and uses them to load a set of bank registers. From those registers it works out which bank of the external program memory backs each CPU read address, and which bank of the external character memory backs each video pattern address. It also reports how the nametables are mirrored. The memories, the interrupt counter and sound generation are outside this block.

Program space is split into three windows. A 16 KiB window covers CPU 0x8000-0xBFFF. A switchable 8 KiB window covers 0xC000-0xDFFF. A fixed 8 KiB window covers 0xE000-0xFFFF and always holds the last bank. Each program bank number is confined to an outer bank by an AND mask and an OR fill value. Character space is split into eight 1 KiB windows, and each window has its own register. `prg_bank` is given in 8 KiB units. For the 16 KiB window, CPU address bit 13 becomes the lowest bit of `prg_bank`.

The design has no sequencing states. Write decoding sorts each write into one of five named targets: `TGT_NONE`, `TGT_PRG16`, `TGT_PRG8`, `TGT_CTRL` and `TGT_CHR`. A register changes only on the clock edge that follows a decoded write. No other transitions exist.

Top module: `cart_bank_mapper`

## Requirements
- R1: A synchronous active-high `rst` clears every register to zero. Afterwards `chr_bank` is 0, `mirror_mode` is 1, and with `or_fill`=0 a read at 0x8000 gives `prg_bank` 0.
- R2: When `cpu_wr_addr[15:12]`=0x8 during a write, the 16 KiB register is loaded. A read in 0x8000-0xBFFF then gives `prg_bank` = {masked 16 KiB bank, `cpu_rd_addr[13]`}.
- R3: When `cpu_wr_addr[15:12]`=0xC during a write, the 8 KiB register is loaded. A read in 0xC000-0xDFFF then gives `prg_bank` = {0, masked 8 KiB bank}.
- R4: A read in 0xE000-0xFFFF gives `prg_bank` = {0, M | (`or_fill` & ~M)}, where M is the 8 KiB mask.
- R5: When `cpu_wr_addr[15:12]` is 0xD or 0xE during a write, a character register is loaded. Its index is {`cpu_wr_addr[13]`, `cpu_wr_addr[1:0]`}, so page 0xD reaches registers 0-3 and page 0xE reaches registers 4-7.
- R6: `chr_bank` is the value of the character register selected by `ppu_addr[12:10]`.
- R7: The 8 KiB mask M is 0x0F when `outer_small`=1 and 0x1F otherwise. The 8 KiB bank is (reg & M) | (`or_fill` & ~M). The 16 KiB bank applies the same rule with M>>1 and `or_fill`>>1.
- R8: When `cpu_wr_addr[15:12]`=0xB, `cpu_wr_addr[1:0]`=3 and a write occurs, the control register is loaded. `mirror_mode` is {c[3], c[2] XNOR c[3]}, which maps c[3:2] as 00→1, 01→0, 10→2, 11→3.
- R9: Some writes leave every register unchanged: writes below 0x8000, writes to pages 0x9, 0xA and 0xF, and writes to page 0xB with low bits other than 3. A write with `cpu_wr_en`=0 also changes nothing. Address bits 11:2 never take part in decoding.
- R10: All outputs follow `cpu_rd_addr` and `ppu_addr` combinationally within the same cycle.
- R11: A read with `cpu_rd_addr[15]`=0 gives `prg_bank` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_wr_addr | input | 16 | CPU write address |
| cpu_wr_data | input | 8 | CPU write data |
| cpu_wr_en | input | 1 | CPU write strobe, sampled on the rising edge |
| cpu_rd_addr | input | 16 | CPU read address to translate |
| ppu_addr | input | 14 | Video address to translate |
| outer_small | input | 1 | 1 selects the narrow outer mask (0x0F) |
| or_fill | input | 8 | Fill bits placed outside the mask |
| prg_bank | output | 9 | Program bank number in 8 KiB units |
| chr_bank | output | 8 | Character bank number in 1 KiB units |
| mirror_mode | output | 2 | Nametable mirroring mode |

## Verification
The bench uses the default 8-bit register width and eight character windows. With these values, the masks 0x0F and 0x1F make only a few low register bits count, so fill bits show up clearly above the mask. The vector table runs with the wide mask and a zero fill. The directed tests then switch `outer_small` and set `or_fill` to 0xA5, so that every window is checked under both outer-bank sizes and the odd fill bit shows the 16 KiB shift.

// File: rtl/cart_map_pkg.sv
package cart_map_pkg;
    localparam int DATA_W    = 8;
    localparam int ADDR_W    = 16;
    localparam int PPU_W     = 14;
    localparam int CHR_COUNT = 8;
    localparam int CHR_IDX_W = $clog2(CHR_COUNT);
    localparam int PRG_W     = DATA_W + 1;
    localparam int WIN_LSB   = 10;

    localparam logic [DATA_W-1:0] MASK_WIDE   = 8'h1F;
    localparam logic [DATA_W-1:0] MASK_NARROW = 8'h0F;

    typedef enum logic [2:0] {
        TGT_NONE,
        TGT_PRG16,
        TGT_PRG8,
        TGT_CTRL,
        TGT_CHR
    } wr_tgt_e;
endpackage

// File: rtl/cart_wr_decode.sv
module cart_wr_decode
    import cart_map_pkg::*;
(
    input  logic                 wr_en,
    input  logic [3:0]           page,
    input  logic [1:0]           low,
    output wr_tgt_e              tgt,
    output logic [CHR_IDX_W-1:0] chr_idx
);
    always_comb begin
        tgt     = TGT_NONE;
        chr_idx = '0;
        if (wr_en) begin
            unique case (page)
                4'h8: tgt = TGT_PRG16;
                4'hB: tgt = (low == 2'b11) ? TGT_CTRL : TGT_NONE;
                4'hC: tgt = TGT_PRG8;
                4'hD, 4'hE: begin
                    tgt     = TGT_CHR;
                    chr_idx = {page[1], low};
                end
                default: tgt = TGT_NONE;
            endcase
        end
    end
endmodule

// File: rtl/cart_bank_regs.sv
module cart_bank_regs
    import cart_map_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst,
    input  wr_tgt_e                       tgt,
    input  logic [CHR_IDX_W-1:0]          chr_idx,
    input  logic [DATA_W-1:0]             wr_data,
    output logic [DATA_W-1:0]             prg16_q,
    output logic [DATA_W-1:0]             prg8_q,
    output logic [DATA_W-1:0]             ctrl_q,
    output logic [CHR_COUNT*DATA_W-1:0]   chr_flat
);
    always_ff @(posedge clk) begin
        if (rst) begin
            prg16_q <= '0;
            prg8_q  <= '0;
            ctrl_q  <= '0;
        end else begin
            if (tgt == TGT_PRG16) prg16_q <= wr_data;
            if (tgt == TGT_PRG8)  prg8_q  <= wr_data;
            if (tgt == TGT_CTRL)  ctrl_q  <= wr_data;
        end
    end

    for (genvar g = 0; g < CHR_COUNT; g++) begin : g_chr
        logic [DATA_W-1:0] q;
        always_ff @(posedge clk) begin
            if (rst) begin
                q <= '0;
            end else if (tgt == TGT_CHR && chr_idx == CHR_IDX_W'(g)) begin
                q <= wr_data;
            end
        end
        assign chr_flat[g*DATA_W +: DATA_W] = q;
    end
endmodule

// File: rtl/cart_bank_xlate.sv
module cart_bank_xlate
    import cart_map_pkg::*;
(
    input  logic [DATA_W-1:0]           prg16_q,
    input  logic [DATA_W-1:0]           prg8_q,
    input  logic [DATA_W-1:0]           ctrl_q,
    input  logic [CHR_COUNT*DATA_W-1:0] chr_flat,
    input  logic [2:0]                  rd_top,
    input  logic [CHR_IDX_W-1:0]        win_idx,
    input  logic                        outer_small,
    input  logic [DATA_W-1:0]           or_fill,
    output logic [PRG_W-1:0]            prg_bank,
    output logic [DATA_W-1:0]           chr_bank,
    output logic [1:0]                  mirror_mode
);
    logic [DATA_W-1:0] mask8, mask16, fill16;
    logic [DATA_W-1:0] bank16, bank8, bank_fix;

    always_comb begin
        mask8    = outer_small ? MASK_NARROW : MASK_WIDE;
        mask16   = mask8 >> 1;
        fill16   = or_fill >> 1;
        bank16   = (prg16_q & mask16) | (fill16 & ~mask16);
        bank8    = (prg8_q & mask8) | (or_fill & ~mask8);
        bank_fix = mask8 | (or_fill & ~mask8);
    end

    always_comb begin
        unique case (rd_top)
            3'b100, 3'b101: prg_bank = {bank16, rd_top[0]};
            3'b110:         prg_bank = {1'b0, bank8};
            3'b111:         prg_bank = {1'b0, bank_fix};
            default:        prg_bank = '0;
        endcase
    end

    assign chr_bank    = chr_flat[win_idx*DATA_W +: DATA_W];
    assign mirror_mode = {ctrl_q[3], ctrl_q[2] ~^ ctrl_q[3]};
endmodule

// File: rtl/cart_bank_mapper.sv
module cart_bank_mapper
    import cart_map_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [15:0]       cpu_wr_addr,
    input  logic [7:0]        cpu_wr_data,
    input  logic              cpu_wr_en,
    input  logic [15:0]       cpu_rd_addr,
    input  logic [13:0]       ppu_addr,
    input  logic              outer_small,
    input  logic [7:0]        or_fill,
    output logic [8:0]        prg_bank,
    output logic [7:0]        chr_bank,
    output logic [1:0]        mirror_mode
);
    wr_tgt_e                       tgt;
    logic [CHR_IDX_W-1:0]          chr_idx;
    logic [DATA_W-1:0]             prg16_q, prg8_q, ctrl_q;
    logic [CHR_COUNT*DATA_W-1:0]   chr_flat;
    logic                          unused_bits;

    assign unused_bits = ^{cpu_wr_addr[11:2], cpu_rd_addr[12:0],
                           ppu_addr[13], ppu_addr[9:0]};

    cart_wr_decode dec_i (
        .wr_en   (cpu_wr_en),
        .page    (cpu_wr_addr[15:12]),
        .low     (cpu_wr_addr[1:0]),
        .tgt     (tgt),
        .chr_idx (chr_idx)
    );

    cart_bank_regs regs_i (
        .clk      (clk),
        .rst      (rst),
        .tgt      (tgt),
        .chr_idx  (chr_idx),
        .wr_data  (cpu_wr_data),
        .prg16_q  (prg16_q),
        .prg8_q   (prg8_q),
        .ctrl_q   (ctrl_q),
        .chr_flat (chr_flat)
    );

    cart_bank_xlate xl_i (
        .prg16_q     (prg16_q),
        .prg8_q      (prg8_q),
        .ctrl_q      (ctrl_q),
        .chr_flat    (chr_flat),
        .rd_top      (cpu_rd_addr[15:13]),
        .win_idx     (ppu_addr[WIN_LSB +: CHR_IDX_W]),
        .outer_small (outer_small),
        .or_fill     (or_fill),
        .prg_bank    (prg_bank),
        .chr_bank    (chr_bank),
        .mirror_mode (mirror_mode)
    );
endmodule

// File: rtl/cart_bank_mapper_chk.sv
module cart_bank_mapper_chk (
    input logic        clk,
    input logic        rst,
    input logic [15:0] cpu_wr_addr,
    input logic [7:0]  cpu_wr_data,
    input logic        cpu_wr_en,
    input logic [15:0] cpu_rd_addr,
    input logic        outer_small,
    input logic [7:0]  or_fill,
    input logic [8:0]  prg_bank,
    input logic [7:0]  chr_bank,
    input logic [1:0]  mirror_mode
);
    p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (mirror_mode == 2'd1 && chr_bank == 8'h00));

    p_fixed_bank_r4: assert property (@(posedge clk) disable iff (rst)
        (cpu_rd_addr[15:13] == 3'b111) |->
        prg_bank == {1'b0, outer_small ? (8'h0F | (or_fill & 8'hF0))
                                       : (8'h1F | (or_fill & 8'hE0))});

    p_mirror_load_r8: assert property (@(posedge clk) disable iff (rst)
        (cpu_wr_en && cpu_wr_addr[15:12] == 4'hB && cpu_wr_addr[1:0] == 2'b11) |=>
        mirror_mode == {$past(cpu_wr_data[3]), ~($past(cpu_wr_data[2]) ^ $past(cpu_wr_data[3]))});

    p_idle_stable_r9: assert property (@(posedge clk) disable iff (rst)
        !cpu_wr_en |=> $stable(mirror_mode));

    p_low_read_r11: assert property (@(posedge clk) disable iff (rst)
        !cpu_rd_addr[15] |-> prg_bank == 9'h000);
endmodule

bind cart_bank_mapper cart_bank_mapper_chk chk_i (
    .clk         (clk),
    .rst         (rst),
    .cpu_wr_addr (cpu_wr_addr),
    .cpu_wr_data (cpu_wr_data),
    .cpu_wr_en   (cpu_wr_en),
    .cpu_rd_addr (cpu_rd_addr),
    .outer_small (outer_small),
    .or_fill     (or_fill),
    .prg_bank    (prg_bank),
    .chr_bank    (chr_bank),
    .mirror_mode (mirror_mode)
);

// File: tb/cart_bank_mapper_tb_top.sv
`timescale 1ns/1ps
module cart_bank_mapper_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] cpu_wr_addr = '0;
    logic [7:0]  cpu_wr_data = '0;
    logic        cpu_wr_en = 1'b0;
    logic [15:0] cpu_rd_addr = '0;
    logic [13:0] ppu_addr = '0;
    logic        outer_small = 1'b0;
    logic [7:0]  or_fill = '0;
    logic [8:0]  prg_bank;
    logic [7:0]  chr_bank;
    logic [1:0]  mirror_mode;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    cart_bank_mapper dut_i (
        .clk(clk), .rst(rst), .cpu_wr_addr(cpu_wr_addr), .cpu_wr_data(cpu_wr_data),
        .cpu_wr_en(cpu_wr_en), .cpu_rd_addr(cpu_rd_addr), .ppu_addr(ppu_addr),
        .outer_small(outer_small), .or_fill(or_fill), .prg_bank(prg_bank),
        .chr_bank(chr_bank), .mirror_mode(mirror_mode)
    );

    // Fields: we[77] waddr[76:61] wdata[60:53] raddr[52:37] paddr[36:23]
    //         prg[22:14] chr[13:6] mir[5:4] req[3:0]; wide mask, zero fill
    localparam int NV = 21;
    localparam logic [77:0] VEC [NV] = '{
        {1'b1,16'h8000,8'h05,16'h8000,14'h0000,9'h00A,8'h00,2'd1,4'd2},  // R2
        {1'b0,16'h0000,8'h00,16'hA000,14'h0000,9'h00B,8'h00,2'd1,4'd2},  // R2 bit13
        {1'b1,16'h8003,8'h13,16'h9FFF,14'h0000,9'h006,8'h00,2'd1,4'd7},  // R7 mask16
        {1'b1,16'hC001,8'h1A,16'hC000,14'h0000,9'h01A,8'h00,2'd1,4'd3},  // R3
        {1'b1,16'hC002,8'h27,16'hD123,14'h0000,9'h007,8'h00,2'd1,4'd7},  // R7 mask8
        {1'b1,16'hD000,8'h11,16'hE000,14'h0000,9'h01F,8'h11,2'd1,4'd5},  // R5 / R4
        {1'b1,16'hD003,8'h22,16'h8000,14'h0C00,9'h006,8'h22,2'd1,4'd5},  // R5
        {1'b1,16'hE000,8'h33,16'h8000,14'h1000,9'h006,8'h33,2'd1,4'd5},  // R5 page E
        {1'b1,16'hE002,8'h44,16'h8000,14'h1BFF,9'h006,8'h44,2'd1,4'd6},  // R6
        {1'b0,16'h0000,8'h00,16'h8000,14'h03FF,9'h006,8'h11,2'd1,4'd6},  // R6
        {1'b1,16'hB003,8'h00,16'h8000,14'h0400,9'h006,8'h00,2'd1,4'd8},  // R8 00->1
        {1'b1,16'hB003,8'h04,16'h8000,14'h0400,9'h006,8'h00,2'd0,4'd8},  // R8 01->0
        {1'b1,16'hB003,8'h08,16'h8000,14'h0400,9'h006,8'h00,2'd2,4'd8},  // R8 10->2
        {1'b1,16'hB003,8'h0C,16'h8000,14'h0400,9'h006,8'h00,2'd3,4'd8},  // R8 11->3
        {1'b1,16'h7003,8'hFF,16'h8000,14'h0000,9'h006,8'h11,2'd3,4'd9},  // R9 low
        {1'b1,16'hF000,8'hFF,16'h8000,14'h0000,9'h006,8'h11,2'd3,4'd9},  // R9 page F
        {1'b1,16'hB000,8'h00,16'h8000,14'h0000,9'h006,8'h11,2'd3,4'd9},  // R9 B000
        {1'b1,16'h9002,8'h01,16'h8000,14'h0000,9'h006,8'h11,2'd3,4'd9},  // R9 page 9
        {1'b1,16'h8FF1,8'h0E,16'h8000,14'h0000,9'h01C,8'h11,2'd3,4'd9},  // R9 mid bits
        {1'b1,16'hD7FE,8'h55,16'h8000,14'h0800,9'h01C,8'h55,2'd3,4'd5},  // R5 mid bits
        {1'b0,16'h0000,8'h00,16'h6000,14'h0800,9'h000,8'h55,2'd3,4'd11}  // R11
    };

    task automatic check(input int req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL R%0d %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic write_reg(input logic [15:0] a, input logic [7:0] d, input logic en);
        @(negedge clk);
        cpu_wr_addr = a;
        cpu_wr_data = d;
        cpu_wr_en   = en;
        @(posedge clk);
        #1 cpu_wr_en = 1'b0;
    endtask

    initial begin
        #(5.0 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (2) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        cpu_rd_addr = 16'h8000;
        #1;
        check(1, "prg after reset", int'(prg_bank), 0);   // R1
        check(1, "chr after reset", int'(chr_bank), 0);
        check(1, "mir after reset", int'(mirror_mode), 1);

        for (int i = 0; i < NV; i++) begin
            logic [77:0] v;
            v = VEC[i];
            write_reg(v[76:61], v[60:53], v[77]);
            cpu_rd_addr = v[52:37];
            ppu_addr    = v[36:23];
            #1;
            check(int'(v[3:0]), "prg", int'(prg_bank), int'(v[22:14]));
            check(int'(v[3:0]), "chr", int'(chr_bank), int'(v[13:6]));
            check(int'(v[3:0]), "mir", int'(mirror_mode), int'(v[5:4]));
        end

        // R10: outputs follow addresses with no clock edge in between
        ppu_addr = 14'h1800; #1;
        check(10, "chr comb", int'(chr_bank), 8'h44);
        cpu_rd_addr = 16'hC000; #1;
        check(10, "prg comb", int'(prg_bank), 9'h007);

        // R4 / R7 with narrow mask and fill 0xA5
        outer_small = 1'b1; or_fill = 8'hA5;
        cpu_rd_addr = 16'hE000; #1;
        check(4, "fixed narrow", int'(prg_bank), 9'h0AF);
        cpu_rd_addr = 16'hC000; #1;
        check(7, "8k narrow fill", int'(prg_bank), 9'h0A7);
        cpu_rd_addr = 16'h8000; #1;
        check(7, "16k narrow fill", int'(prg_bank), 9'h0AC);
        outer_small = 1'b0;
        cpu_rd_addr = 16'hFFFF; #1;
        check(4, "fixed wide", int'(prg_bank), 9'h0BF);
        cpu_rd_addr = 16'hA000; #1;
        check(7, "16k wide fill", int'(prg_bank), 9'h0BD);

        // R9: strobe low at a decoded address
        write_reg(16'hB003, 8'h00, 1'b0);
        #1 check(9, "no strobe", int'(mirror_mode), 3);

        // R1: reset in the middle of a run
        @(negedge clk) rst = 1'b1;
        @(posedge clk);
        #1 rst = 1'b0;
        ppu_addr = 14'h0800; or_fill = 8'h00; cpu_rd_addr = 16'h8000; #1;
        check(1, "chr mid reset", int'(chr_bank), 0);
        check(1, "mir mid reset", int'(mirror_mode), 1);
        check(1, "prg mid reset", int'(prg_bank), 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule